// File: doc/BRIEF.md
# Way-Tagged L2 Write Steering

This block sits between an L1 data cache and a set-associative L2 in an inclusive, write-through hierarchy. For every L1 line it keeps the number of the L2 way that supplied the line. When L1 fills a line, the L2 way index comes back with the fill and is recorded against that L1 set and way. A later store that hits the same L1 line then reaches L2 with a single way enable. The L2 skips its tag compare for that store and behaves like a direct-mapped array.

Every other access gets the enables of all L2 ways at once. That covers reads, L1 misses, and stores to a line whose way number is unknown or has been invalidated by an L2 eviction. Each steered access is shown on a stage port one cycle after it is accepted. It then enters a small in-order queue toward L2. Write-through stores can therefore retire at the core while L2 is busy. The queue pushes back on the requester only when it is full.

Top module: `wt_l2_steer`

## Requirements
- R1: After reset, and after any later reset, `req_ready` is 1, `st_valid` and `l2_valid` are 0, and every stored way number is invalid.
- R2: A store that hits in L1 (`req_write`=1, `req_l1hit`=1) on an entry with a valid way number w produces, in the cycle after acceptance, `st_valid`=1, `st_direct`=1, `st_way_en` with only bit w set, and `st_l2way`=w.
- R3: A read (`req_write`=0) or an L1 miss (`req_l1hit`=0) produces, in the cycle after acceptance, `st_direct`=0 and `st_way_en` all ones, whatever is stored.
- R4: A store that hits in L1 on an entry that was never filled produces `st_direct`=0 and all-ones `st_way_en`.
- R5: A fill is seen by requests accepted from the cycle after the fill onward. A request in the same cycle as the fill for the same entry sees the previous contents.
- R6: An eviction invalidates its entry, so later store hits steer to all ways while other entries are kept. An eviction also cancels a fill of the same entry that was taken one cycle earlier and not yet written.
- R7: A second fill of an entry replaces its way number.
- R8: Accesses leave on the L2 port in acceptance order, each with its own write flag, enables, address and data. While `l2_valid`=1 and `l2_ready`=0, the L2 port outputs hold steady.
- R9: With `l2_ready` held at 0, exactly four requests (the queue depth) are accepted and `req_ready` then falls. No access is lost or duplicated.
- R10: Entries are kept per L1 set and L1 way. A fill of one (set, way) pair does not change another pair of the same set or the same pair of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | L1 line fill from L2 this cycle |
| fill_set | input | 6 | L1 set of the filled line |
| fill_way | input | 1 | L1 way of the filled line |
| fill_l2way | input | 2 | L2 way that supplied the line |
| evict_valid | input | 1 | L2 evicted a line that L1 holds |
| evict_set | input | 6 | L1 set of the evicted line |
| evict_way | input | 1 | L1 way of the evicted line |
| req_valid | input | 1 | Access request toward L2 |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 store, 0 read |
| req_l1hit | input | 1 | Access hit in L1 |
| req_set | input | 6 | L1 set of the access |
| req_way | input | 1 | L1 way hit by the access |
| req_addr | input | 32 | Access address |
| req_data | input | 32 | Store data |
| st_valid | output | 1 | Steered access, one cycle after acceptance |
| st_direct | output | 1 | Steered access uses a single L2 way |
| st_way_en | output | 4 | Decoded L2 way enables |
| st_l2way | output | 2 | L2 way number when direct, else 0 |
| l2_valid | output | 1 | Queue head holds an access |
| l2_ready | input | 1 | L2 takes the head access |
| l2_write | output | 1 | Head access is a store |
| l2_way_en | output | 4 | Head access way enables |
| l2_addr | output | 32 | Head access address |
| l2_data | output | 32 | Head access data |

## Verification
The hardest cases to reach from the ports depend on exact timing: a fill's way number is still in the way register, not yet in the array, when a request or an eviction for the same entry arrives. The stimulus uses a vector table so that a store hit lands in the very cycle after a fill, which exercises the bypass. Directed sequences then put the fill and the request in the same cycle, and put an eviction right behind a fill, so the cancelled write can be seen through later store hits. Backpressure is reached by holding the L2 ready low until the queue stalls, then draining it and comparing order and contents.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int unsigned DEF_L2_WAYS  = 4;
  localparam int unsigned DEF_L1_SETS  = 64;
  localparam int unsigned DEF_L1_WAYS  = 2;
  localparam int unsigned DEF_WB_DEPTH = 4;
  localparam int unsigned DEF_ADDR_W   = 32;
  localparam int unsigned DEF_DATA_W   = 32;

  // how a steered access reaches the L2 ways
  typedef enum logic {
    PATH_ALL    = 1'b0,
    PATH_DIRECT = 1'b1
  } path_e;
endpackage

// File: rtl/wt_tag_store.sv
module wt_tag_store #(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             evict_valid,
  input  logic [IDX_W-1:0] evict_idx,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  // way register: holds the incoming way number for one cycle
  logic             wreg_pend;
  logic [IDX_W-1:0] wreg_idx;
  logic [TAG_W-1:0] wreg_tag;

  logic [TAG_W-1:0] tag_mem [ENTRIES];
  logic [ENTRIES-1:0] vld;

  // way-tag buffer register and bypass capture
  logic [TAG_W-1:0] buf_q;
  logic             byp_q;
  logic [TAG_W-1:0] byp_tag_q;

  logic wr_en;
  logic byp;

  assign wr_en = wreg_pend && !(evict_valid && (evict_idx == wreg_idx));
  assign byp   = wr_en && (wreg_idx == rd_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      wreg_pend <= 1'b0;
    end else begin
      wreg_pend <= fill_valid && !(evict_valid && (evict_idx == fill_idx));
    end
    if (fill_valid) begin
      wreg_idx <= fill_idx;
      wreg_tag <= fill_tag;
    end
  end

  // array written and read in the block RAM style
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wreg_idx] <= wreg_tag;
    if (rd_en) buf_q <= tag_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (wr_en)       vld[wreg_idx]  <= 1'b1;
      if (evict_valid) vld[evict_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      byp_q     <= 1'b0;
      byp_tag_q <= '0;
    end else if (rd_en) begin
      rd_valid  <= byp ? 1'b1 : vld[rd_idx];
      byp_q     <= byp;
      byp_tag_q <= wreg_tag;
    end
  end

  assign rd_tag = byp_q ? byp_tag_q : buf_q;
endmodule

// File: rtl/wt_way_decode.sv
module wt_way_decode #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 2
) (
  input  wt_pkg::path_e    path,
  input  logic [TAG_W-1:0] tag,
  output logic [WAYS-1:0]  way_en
);
  for (genvar i = 0; i < WAYS; i++) begin : g_way
    assign way_en[i] = (path == wt_pkg::PATH_ALL) || (tag == TAG_W'(i));
  end
endmodule

// File: rtl/wt_wbuf.sv
module wt_wbuf #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 69
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic                       head_valid,
  output logic [W-1:0]               head_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             do_pop;

  assign do_pop     = pop && (count != '0);
  assign head_valid = (count != '0);
  assign head_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wt_l2_steer.sv
module wt_l2_steer #(
  parameter int unsigned L2_WAYS  = wt_pkg::DEF_L2_WAYS,
  parameter int unsigned L1_SETS  = wt_pkg::DEF_L1_SETS,
  parameter int unsigned L1_WAYS  = wt_pkg::DEF_L1_WAYS,
  parameter int unsigned WB_DEPTH = wt_pkg::DEF_WB_DEPTH,
  parameter int unsigned ADDR_W   = wt_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W   = wt_pkg::DEF_DATA_W,
  localparam int unsigned SET_W   = $clog2(L1_SETS),
  localparam int unsigned LW_W    = (L1_WAYS > 1) ? $clog2(L1_WAYS) : 1,
  localparam int unsigned TAG_W   = (L2_WAYS > 1) ? $clog2(L2_WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_valid,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [LW_W-1:0]   fill_way,
  input  logic [TAG_W-1:0]  fill_l2way,
  input  logic              evict_valid,
  input  logic [SET_W-1:0]  evict_set,
  input  logic [LW_W-1:0]   evict_way,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_l1hit,
  input  logic [SET_W-1:0]  req_set,
  input  logic [LW_W-1:0]   req_way,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              st_valid,
  output logic              st_direct,
  output logic [L2_WAYS-1:0] st_way_en,
  output logic [TAG_W-1:0]  st_l2way,
  output logic              l2_valid,
  input  logic              l2_ready,
  output logic              l2_write,
  output logic [L2_WAYS-1:0] l2_way_en,
  output logic [ADDR_W-1:0] l2_addr,
  output logic [DATA_W-1:0] l2_data
);
  localparam int unsigned IDX_W = SET_W + LW_W;
  localparam int unsigned ENT_W = 1 + L2_WAYS + ADDR_W + DATA_W;
  localparam int unsigned CNT_W = $clog2(WB_DEPTH + 1);

  logic              accept;
  logic              st_valid_q;
  logic              st_wrhit_q;
  logic              st_write_q;
  logic [ADDR_W-1:0] st_addr_q;
  logic [DATA_W-1:0] st_data_q;

  logic [TAG_W-1:0]  tag_rd;
  logic              tag_ok;
  wt_pkg::path_e     path;
  logic [L2_WAYS-1:0] dec_en;

  logic [CNT_W-1:0]  wb_count;
  logic [CNT_W:0]    occ;
  logic [ENT_W-1:0]  head;

  // accept only while the stage plus queue has a free slot
  assign occ       = {1'b0, wb_count} + (CNT_W + 1)'(st_valid_q);
  assign req_ready = (occ < (CNT_W + 1)'(WB_DEPTH));
  assign accept    = req_valid && req_ready;

  wt_tag_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_store (
    .clk         (clk),
    .rst         (rst),
    .fill_valid  (fill_valid),
    .fill_idx    ({fill_set, fill_way}),
    .fill_tag    (fill_l2way),
    .evict_valid (evict_valid),
    .evict_idx   ({evict_set, evict_way}),
    .rd_en       (accept),
    .rd_idx      ({req_set, req_way}),
    .rd_tag      (tag_rd),
    .rd_valid    (tag_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid_q <= 1'b0;
      st_wrhit_q <= 1'b0;
      st_write_q <= 1'b0;
    end else begin
      st_valid_q <= accept;
      if (accept) begin
        st_wrhit_q <= req_write && req_l1hit;
        st_write_q <= req_write;
      end
    end
    if (accept) begin
      st_addr_q <= req_addr;
      st_data_q <= req_data;
    end
  end

  assign path = (st_wrhit_q && tag_ok) ? wt_pkg::PATH_DIRECT : wt_pkg::PATH_ALL;

  wt_way_decode #(
    .WAYS  (L2_WAYS),
    .TAG_W (TAG_W)
  ) u_dec (
    .path   (path),
    .tag    (tag_rd),
    .way_en (dec_en)
  );

  assign st_valid  = st_valid_q;
  assign st_direct = st_valid_q && (path == wt_pkg::PATH_DIRECT);
  assign st_way_en = st_valid_q ? dec_en : '0;
  assign st_l2way  = st_direct ? tag_rd : '0;

  wt_wbuf #(
    .DEPTH (WB_DEPTH),
    .W     (ENT_W)
  ) u_wbuf (
    .clk        (clk),
    .rst        (rst),
    .push       (st_valid_q),
    .push_data  ({st_write_q, dec_en, st_addr_q, st_data_q}),
    .pop        (l2_ready),
    .head_valid (l2_valid),
    .head_data  (head),
    .count      (wb_count)
  );

  assign {l2_write, l2_way_en, l2_addr, l2_data} = head;
endmodule

// File: rtl/wt_l2_steer_chk.sv
module wt_l2_steer_chk #(
  parameter int unsigned L2_WAYS  = 4,
  parameter int unsigned WB_DEPTH = 4,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_l1hit,
  input logic              st_valid,
  input logic              st_direct,
  input logic [L2_WAYS-1:0] st_way_en,
  input logic              l2_valid,
  input logic              l2_ready,
  input logic              l2_write,
  input logic [L2_WAYS-1:0] l2_way_en,
  input logic [ADDR_W-1:0] l2_addr,
  input logic [DATA_W-1:0] l2_data
);
  // accesses held between acceptance and L2 hand-off, seen from the ports
  logic [7:0] held;
  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else held <= held + 8'(req_valid && req_ready) - 8'(l2_valid && l2_ready);
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!st_valid && !l2_valid && req_ready));

  assert_single_way_R2: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_direct) |-> ($countones(st_way_en) == 1));

  assert_stage_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> st_valid);

  assert_all_ways_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !(req_write && req_l1hit)) |=> (st_valid && !st_direct && (&st_way_en)));

  assert_head_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (l2_valid && !l2_ready) |=> (l2_valid && $stable(l2_addr) && $stable(l2_data)
                                 && $stable(l2_way_en) && $stable(l2_write)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (req_ready == (held < 8'(WB_DEPTH))) && (held <= 8'(WB_DEPTH)));
endmodule

bind wt_l2_steer wt_l2_steer_chk #(
  .L2_WAYS  (L2_WAYS),
  .WB_DEPTH (WB_DEPTH),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_l1hit (req_l1hit),
  .st_valid  (st_valid),
  .st_direct (st_direct),
  .st_way_en (st_way_en),
  .l2_valid  (l2_valid),
  .l2_ready  (l2_ready),
  .l2_write  (l2_write),
  .l2_way_en (l2_way_en),
  .l2_addr   (l2_addr),
  .l2_data   (l2_data)
);

// File: tb/sim_wt_l2_steer.sv
module sim_wt_l2_steer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic fill_valid = 0; logic [5:0] fill_set = 0; logic fill_way = 0; logic [1:0] fill_l2way = 0;
  logic evict_valid = 0; logic [5:0] evict_set = 0; logic evict_way = 0;
  logic req_valid = 0; logic req_write = 0; logic req_l1hit = 0;
  logic [5:0] req_set = 0; logic req_way = 0;
  logic [31:0] req_addr = 0; logic [31:0] req_data = 0;
  logic l2_ready = 1'b1;
  logic req_ready, st_valid, st_direct, l2_valid, l2_write;
  logic [3:0] st_way_en, l2_way_en;
  logic [1:0] st_l2way;
  logic [31:0] l2_addr, l2_data;

  wt_l2_steer u0 (
    .clk(clk), .rst(rst),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way), .fill_l2way(fill_l2way),
    .evict_valid(evict_valid), .evict_set(evict_set), .evict_way(evict_way),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_l1hit(req_l1hit),
    .req_set(req_set), .req_way(req_way), .req_addr(req_addr), .req_data(req_data),
    .st_valid(st_valid), .st_direct(st_direct), .st_way_en(st_way_en), .st_l2way(st_l2way),
    .l2_valid(l2_valid), .l2_ready(l2_ready), .l2_write(l2_write), .l2_way_en(l2_way_en),
    .l2_addr(l2_addr), .l2_data(l2_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // op: 0 request, 1 fill, 2 evict; for requests l2w is the expected way when direct
  typedef struct packed {
    logic [1:0] op;
    logic [5:0] set;
    logic       way;
    logic [1:0] l2w;
    logic       wr;
    logic       hit;
    logic [3:0] en;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TAB [NV] = '{
    '{2'd0, 6'd3,  1'b0, 2'd0, 1'b1, 1'b1, 4'hF, 4'd4},
    '{2'd1, 6'd3,  1'b0, 2'd2, 1'b0, 1'b0, 4'h0, 4'd0},
    '{2'd0, 6'd3,  1'b0, 2'd2, 1'b1, 1'b1, 4'h4, 4'd5},
    '{2'd0, 6'd3,  1'b0, 2'd0, 1'b0, 1'b1, 4'hF, 4'd3},
    '{2'd0, 6'd3,  1'b0, 2'd0, 1'b1, 1'b0, 4'hF, 4'd3},
    '{2'd0, 6'd3,  1'b1, 2'd0, 1'b1, 1'b1, 4'hF, 4'd10},
    '{2'd1, 6'd3,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 4'd0},
    '{2'd0, 6'd4,  1'b1, 2'd0, 1'b1, 1'b1, 4'hF, 4'd10},
    '{2'd0, 6'd3,  1'b1, 2'd1, 1'b1, 1'b1, 4'h2, 4'd2},
    '{2'd1, 6'd3,  1'b0, 2'd3, 1'b0, 1'b0, 4'h0, 4'd0},
    '{2'd0, 6'd3,  1'b0, 2'd3, 1'b1, 1'b1, 4'h8, 4'd7},
    '{2'd2, 6'd3,  1'b0, 2'd0, 1'b0, 1'b0, 4'h0, 4'd0},
    '{2'd0, 6'd3,  1'b0, 2'd0, 1'b1, 1'b1, 4'hF, 4'd6},
    '{2'd0, 6'd3,  1'b1, 2'd1, 1'b1, 1'b1, 4'h2, 4'd6},
    '{2'd1, 6'd63, 1'b1, 2'd0, 1'b0, 1'b0, 4'h0, 4'd0},
    '{2'd0, 6'd63, 1'b1, 2'd0, 1'b1, 1'b1, 4'h1, 4'd2}
  };

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd2: return "R2"; 4'd3: return "R3"; 4'd4: return "R4"; 4'd5: return "R5";
      4'd6: return "R6"; 4'd7: return "R7"; default: return "R10";
    endcase
  endfunction

  task automatic idle_inputs();
    fill_valid = 0; evict_valid = 0; req_valid = 0;
  endtask

  // drive one request now (at a falling edge), check steering one edge later
  task automatic do_req(input logic [5:0] s, input logic w, input logic wr, input logic hit,
                        input logic [3:0] en, input logic [1:0] way, input string rq);
    req_valid = 1; req_set = s; req_way = w; req_write = wr; req_l1hit = hit;
    req_addr = {26'h0, s}; req_data = 32'hD000 + {26'h0, s};
    @(negedge clk);
    idle_inputs();
    check(rq, {63'h0, st_valid}, 64'h1);
    check(rq, {60'h0, st_way_en}, {60'h0, en});
    check(rq, {63'h0, st_direct}, {63'h0, (en != 4'hF)});
    if (en != 4'hF) check(rq, {62'h0, st_l2way}, {62'h0, way});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1", {63'h0, req_ready}, 64'h1);
    check("R1", {63'h0, st_valid}, 64'h0);
    check("R1", {63'h0, l2_valid}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (TAB[i].op == 2'd1) begin
        fill_valid = 1; fill_set = TAB[i].set; fill_way = TAB[i].way; fill_l2way = TAB[i].l2w;
        @(negedge clk);
        idle_inputs();
      end else if (TAB[i].op == 2'd2) begin
        evict_valid = 1; evict_set = TAB[i].set; evict_way = TAB[i].way;
        @(negedge clk);
        idle_inputs();
      end else begin
        do_req(TAB[i].set, TAB[i].way, TAB[i].wr, TAB[i].hit, TAB[i].en, TAB[i].l2w,
               rname(TAB[i].rq));
      end
    end
    repeat (3) @(negedge clk);

    // R5: fill and request to the same entry in one cycle
    fill_valid = 1; fill_set = 6'd10; fill_way = 0; fill_l2way = 2'd1;
    do_req(6'd10, 1'b0, 1'b1, 1'b1, 4'hF, 2'd0, "R5");
    do_req(6'd10, 1'b0, 1'b1, 1'b1, 4'h2, 2'd1, "R5");

    // R6: eviction right behind a fill cancels it
    fill_valid = 1; fill_set = 6'd20; fill_way = 1; fill_l2way = 2'd3;
    @(negedge clk);
    idle_inputs();
    evict_valid = 1; evict_set = 6'd20; evict_way = 1;
    @(negedge clk);
    idle_inputs();
    do_req(6'd20, 1'b1, 1'b1, 1'b1, 4'hF, 2'd0, "R6");
    do_req(6'd20, 1'b1, 1'b1, 1'b1, 4'hF, 2'd0, "R6");
    repeat (3) @(negedge clk);

    // R9/R8: backpressure, then ordered drain
    l2_ready = 0;
    for (int i = 0; i < 6; i++) begin
      check("R9", {63'h0, req_ready}, {63'h0, (i < 4)});
      req_valid = 1; req_set = 6'd10; req_way = 0;
      req_write = (i == 0); req_l1hit = 1;
      req_addr = 32'hA0 + 32'(i); req_data = 32'hB0 + 32'(i);
      @(negedge clk);
    end
    idle_inputs();
    @(negedge clk);
    check("R9", {63'h0, req_ready}, 64'h0);
    check("R8", {63'h0, l2_valid}, 64'h1);
    check("R8", {32'h0, l2_addr}, 64'hA0);
    @(negedge clk);
    check("R8", {32'h0, l2_addr}, 64'hA0);
    l2_ready = 1;
    for (int k = 0; k < 4; k++) begin
      check("R8", {63'h0, l2_valid}, 64'h1);
      check("R8", {32'h0, l2_addr}, 64'hA0 + 64'(k));
      check("R8", {32'h0, l2_data}, 64'hB0 + 64'(k));
      check("R8", {63'h0, l2_write}, {63'h0, (k == 0)});
      check("R8", {60'h0, l2_way_en}, (k == 0) ? 64'h2 : 64'hF);
      @(negedge clk);
    end
    check("R9", {63'h0, l2_valid}, 64'h0);
    check("R9", {63'h0, req_ready}, 64'h1);

    // R1: a later reset clears stored way numbers
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    check("R1", {63'h0, st_valid}, 64'h0);
    check("R1", {63'h0, l2_valid}, 64'h0);
    do_req(6'd3, 1'b1, 1'b1, 1'b1, 4'hF, 2'd0, "R1");
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule